// File: doc/BRIEF.md
# Packed Byte FIFO Pair for a Serial Peripheral Data Path

This block sits between the register-access side of a serial peripheral and its shift engine. It holds outgoing bytes in a small transmit queue and incoming bytes in a small receive queue. Both queues have the same power-of-two byte depth, four by default. Software writes the data register with 8-bit or 16-bit accesses and reads it the same way. The shift engine takes one frame at a time from the head of the transmit queue and hands one frame at a time to the tail of the receive queue.

Frames are at most 8 bits wide, so each queue entry is one byte. A 16-bit access moves two frames, and the lower byte always travels first. Neither status output reports exact empty or full. The transmit flag says there is room for a 16-bit write: the level is at or below half the depth. The receive flag depends on a byte-mode input. With byte mode set, it rises as soon as one quarter of the depth is filled (one byte by default). With byte mode clear, it rises only at half the depth (two bytes), so one flag event matches one 16-bit read. To collect an odd last frame, software sets byte mode so that the lone byte raises the flag, then reads it.

Writes that do not fit and frames that arrive while the receive queue is full are thrown away. Each case sets a sticky error bit, and one clear input resets both bits.

Top module: `spi_pack_fifo`

## Requirements
- R1: After the active-low reset, both queues are empty. The transmit-room flag is 1, and the receive flag, the shifter-valid output, both error bits and the read data are all 0.
- R2: Bytes written with 8-bit writes (wr_wide=0, byte taken from wr_data[7:0]) leave on sh_tx_data in write order. Each accepted pop (sh_tx_valid and sh_tx_ready both high at a clock edge) removes exactly one byte.
- R3: A 16-bit write (wr_wide=1) queues two bytes: wr_data[7:0] is presented to the shifter first, then wr_data[15:8].
- R4: tx_empty_flag is 1 exactly when the transmit level is at most DEPTH/2.
- R5: With byte_mode=1, rx_ne_flag is 1 exactly when the receive level is at least DEPTH/4.
- R6: With byte_mode=0, rx_ne_flag is 1 exactly when the receive level is at least DEPTH/2.
- R7: Read data and what a read removes:
  - rd_data[7:0] always shows the oldest unread byte.
  - With rd_wide=1 and at least two bytes stored, rd_data[15:8] shows the next byte, and a read (rd_en) removes both.
  - Otherwise rd_data[15:8] is 0 and a read removes one byte.
- R8: A write that needs more free bytes than are available stores nothing and sets tx_ovf, which stays set. The queue contents are unchanged.
- R9: A frame pushed by the shifter while the receive queue holds DEPTH bytes is discarded and sets rx_ovr, which stays set. The stored bytes are unchanged.
- R10: Pulsing err_clr, with no new error in the same cycle, clears both tx_ovf and rx_ovr.
- R11: sh_tx_valid is 1 exactly when the transmit queue holds at least one byte.
- R12: A read of an empty receive queue has no effect: rd_data stays 0 and later pushes and reads behave as if the read had not happened.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset, empties both queues |
| wr_en | input | 1 | Data register write strobe |
| wr_wide | input | 1 | 1 = 16-bit write, 0 = 8-bit write |
| wr_data | input | 16 | Write data, low byte sent first |
| rd_en | input | 1 | Data register read strobe (pops) |
| rd_wide | input | 1 | 1 = 16-bit read, 0 = 8-bit read |
| rd_data | output | 16 | Oldest byte low, next byte high on 16-bit reads |
| byte_mode | input | 1 | Selects the receive flag threshold |
| tx_empty_flag | output | 1 | Transmit level at or below half depth |
| rx_ne_flag | output | 1 | Receive level at or above the threshold |
| tx_ovf | output | 1 | Sticky: a write was dropped |
| rx_ovr | output | 1 | Sticky: a received frame was dropped |
| err_clr | input | 1 | Clears both sticky error bits |
| sh_tx_valid | output | 1 | Transmit head byte available |
| sh_tx_data | output | 8 | Transmit head byte |
| sh_tx_ready | input | 1 | Shifter takes the head byte |
| sh_rx_valid | input | 1 | Shifter delivers a byte |
| sh_rx_data | input | 8 | Delivered byte |

## Verification
The bench uses the default DEPTH of 4. At that depth the quarter threshold is one byte and the half threshold is two. Every fill level from 0 to 4 can therefore be reached in a few cycles. The bench sweeps all of these levels for the transmit flag and for the receive flag under both byte-mode settings.

Several byte patterns are generated arithmetically and pushed through the queue. The FIFO pointers wrap many times during these runs. This covers ordering and 16-bit packing at every pointer offset.

The overflow, overrun and odd-tail cases are each one or two bytes away from the limits, so they are driven directly and checked by draining or reading back the stored bytes.

// File: rtl/spi_pack_fifo.sv
module spi_pack_fifo #(
  parameter int DEPTH = 4
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        wr_en,
  input  logic        wr_wide,
  input  logic [15:0] wr_data,
  input  logic        rd_en,
  input  logic        rd_wide,
  output logic [15:0] rd_data,
  input  logic        byte_mode,
  output logic        tx_empty_flag,
  output logic        rx_ne_flag,
  output logic        tx_ovf,
  output logic        rx_ovr,
  input  logic        err_clr,
  output logic        sh_tx_valid,
  output logic [7:0]  sh_tx_data,
  input  logic        sh_tx_ready,
  input  logic        sh_rx_valid,
  input  logic [7:0]  sh_rx_data
);

  localparam int AW = $clog2(DEPTH);
  localparam int CW = AW + 1;
  localparam logic [CW-1:0] FULL  = CW'(DEPTH);
  localparam logic [CW-1:0] HALF  = CW'(DEPTH / 2);
  localparam logic [CW-1:0] QUART = CW'(DEPTH / 4);
  localparam logic [CW-1:0] ONE   = CW'(1);
  localparam logic [CW-1:0] TWO   = CW'(2);

  initial assert (DEPTH >= 4 && (DEPTH & (DEPTH - 1)) == 0)
    else $error("DEPTH must be a power of two, at least 4");

  // transmit side
  logic [7:0]    tx_mem [DEPTH];
  logic [AW-1:0] tx_wp, tx_rp;
  logic [CW-1:0] tx_cnt, wr_n;
  logic          tx_push, tx_drop, tx_pop;

  assign wr_n    = wr_wide ? TWO : ONE;
  assign tx_push = wr_en && (FULL - tx_cnt) >= wr_n;
  assign tx_drop = wr_en && !tx_push;
  assign tx_pop  = sh_tx_valid && sh_tx_ready;

  assign sh_tx_valid   = tx_cnt != '0;
  assign sh_tx_data    = tx_mem[tx_rp];
  assign tx_empty_flag = tx_cnt <= HALF;

  always_ff @(posedge clk) begin
    if (tx_push) begin
      tx_mem[tx_wp] <= wr_data[7:0];
      if (wr_wide) tx_mem[tx_wp + AW'(1)] <= wr_data[15:8];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_wp  <= '0;
      tx_rp  <= '0;
      tx_cnt <= '0;
    end else begin
      if (tx_push) tx_wp <= tx_wp + AW'(wr_n);
      if (tx_pop)  tx_rp <= tx_rp + AW'(1);
      tx_cnt <= tx_cnt + (tx_push ? wr_n : '0) - (tx_pop ? ONE : '0);
    end
  end

  // receive side
  logic [7:0]    rx_mem [DEPTH];
  logic [AW-1:0] rx_wp, rx_rp;
  logic [CW-1:0] rx_cnt, rd_n;
  logic          rx_push, rx_drop, two_avail;

  assign rx_push   = sh_rx_valid && rx_cnt != FULL;
  assign rx_drop   = sh_rx_valid && rx_cnt == FULL;
  assign two_avail = rd_wide && rx_cnt >= TWO;
  assign rd_n      = !rd_en ? '0 : two_avail ? TWO : (rx_cnt != '0) ? ONE : '0;

  assign rd_data[7:0]  = (rx_cnt != '0) ? rx_mem[rx_rp] : 8'h00;
  assign rd_data[15:8] = two_avail ? rx_mem[rx_rp + AW'(1)] : 8'h00;
  assign rx_ne_flag    = rx_cnt >= (byte_mode ? QUART : HALF);

  always_ff @(posedge clk) begin
    if (rx_push) rx_mem[rx_wp] <= sh_rx_data;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rx_wp  <= '0;
      rx_rp  <= '0;
      rx_cnt <= '0;
    end else begin
      if (rx_push) rx_wp <= rx_wp + AW'(1);
      rx_rp  <= rx_rp + AW'(rd_n);
      rx_cnt <= rx_cnt + (rx_push ? ONE : '0) - rd_n;
    end
  end

  // sticky error bits
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      tx_ovf <= 1'b0;
      rx_ovr <= 1'b0;
    end else begin
      tx_ovf <= (tx_ovf && !err_clr) || tx_drop;
      rx_ovr <= (rx_ovr && !err_clr) || rx_drop;
    end
  end

  // R8
  tx_ovf_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(tx_ovf) |-> $past(wr_en));

  // R9
  rx_ovr_cause_chk: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(rx_ovr) |-> ($past(sh_rx_valid) && $past(rx_cnt) == FULL));

  // R11
  tx_valid_room_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !sh_tx_valid |-> tx_empty_flag);

  // R2
  tx_pop_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (tx_pop && !wr_en) |=> tx_cnt == $past(tx_cnt) - ONE);

  // R9
  rx_push_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (sh_rx_valid && !rd_en && rx_cnt != FULL) |=> rx_cnt == $past(rx_cnt) + ONE);

  // R6
  rx_ne_packed_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rx_ne_flag && !byte_mode) |-> two_avail || !rd_wide);

endmodule

// File: tb/test_spi_pack_fifo.sv
module test_spi_pack_fifo;
  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        wr_en = 1'b0, wr_wide = 1'b0, rd_en = 1'b0, rd_wide = 1'b0;
  logic [15:0] wr_data = '0;
  logic [15:0] rd_data;
  logic        byte_mode = 1'b0, err_clr = 1'b0;
  logic        tx_empty_flag, rx_ne_flag, tx_ovf, rx_ovr;
  logic        sh_tx_valid, sh_tx_ready = 1'b0, sh_rx_valid = 1'b0;
  logic [7:0]  sh_tx_data, sh_rx_data = '0;
  int checks = 0, errors = 0;

  always #5 clk = ~clk;

  spi_pack_fifo #(.DEPTH(4)) i_spi_pack_fifo (
    .clk(clk), .rst_n(rst_n), .wr_en(wr_en), .wr_wide(wr_wide), .wr_data(wr_data),
    .rd_en(rd_en), .rd_wide(rd_wide), .rd_data(rd_data), .byte_mode(byte_mode),
    .tx_empty_flag(tx_empty_flag), .rx_ne_flag(rx_ne_flag), .tx_ovf(tx_ovf),
    .rx_ovr(rx_ovr), .err_clr(err_clr), .sh_tx_valid(sh_tx_valid),
    .sh_tx_data(sh_tx_data), .sh_tx_ready(sh_tx_ready),
    .sh_rx_valid(sh_rx_valid), .sh_rx_data(sh_rx_data));

  function automatic logic [7:0] pat(input int k);
    return 8'((k * 53 + 17) & 255);
  endfunction

  task automatic chk(input string req, input int act, input int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic step();
    @(posedge clk); #1;
  endtask

  task automatic tx_wr(input logic wide, input logic [15:0] d);
    wr_en = 1'b1; wr_wide = wide; wr_data = d;
    step();
    wr_en = 1'b0; wr_wide = 1'b0;
  endtask

  task automatic tx_take(input logic [7:0] exp, input string req);
    chk(req, int'(sh_tx_valid), 1);
    chk(req, int'(sh_tx_data), int'(exp));
    sh_tx_ready = 1'b1;
    step();
    sh_tx_ready = 1'b0;
  endtask

  task automatic rx_put(input logic [7:0] d);
    sh_rx_valid = 1'b1; sh_rx_data = d;
    step();
    sh_rx_valid = 1'b0;
  endtask

  task automatic rd(input logic wide, input logic [15:0] exp, input string req);
    rd_wide = wide;
    #1;
    chk(req, int'(rd_data), int'(exp));
    rd_en = 1'b1;
    step();
    rd_en = 1'b0; rd_wide = 1'b0;
  endtask

  task automatic finish_run();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  endtask

  initial begin
    #2000000;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    finish_run();
  end

  initial begin
    int base;
    step(); step();
    rst_n = 1'b1;
    step();
    // R1
    chk("R1 tbe", int'(tx_empty_flag), 1);
    chk("R1 rbne", int'(rx_ne_flag), 0);
    chk("R1 valid", int'(sh_tx_valid), 0);
    chk("R1 ovf", int'(tx_ovf), 0);
    chk("R1 ovr", int'(rx_ovr), 0);
    chk("R1 rd_data", int'(rd_data), 0);

    // R4 R2 R11: every transmit level, several offsets
    base = 0;
    for (int r = 0; r < 3; r++) begin
      for (int lvl = 1; lvl <= 4; lvl++) begin
        tx_wr(1'b0, {8'h00, pat(base + lvl)});
        chk("R4 tbe vs level", int'(tx_empty_flag), int'(lvl <= 2));
        chk("R11 valid", int'(sh_tx_valid), 1);
      end
      for (int k = 1; k <= 4; k++) begin
        tx_take(pat(base + k), "R2 order");
        chk("R4 tbe drain", int'(tx_empty_flag), int'(4 - k <= 2));
      end
      chk("R11 empty", int'(sh_tx_valid), 0);
      base += 4;
      tx_wr(1'b0, 16'h00AA);
      tx_take(8'hAA, "R2 offset");
    end

    // R3: packed writes at every pointer offset
    for (int p = 0; p < 8; p++) begin
      tx_wr(1'b1, {pat(2 * p + 1), pat(2 * p)});
      chk("R3 level", int'(tx_empty_flag), 1);
      tx_wr(1'b1, {pat(2 * p + 41), pat(2 * p + 40)});
      chk("R3 full", int'(tx_empty_flag), 0);
      tx_take(pat(2 * p), "R3 low first");
      tx_take(pat(2 * p + 1), "R3 high second");
      tx_take(pat(2 * p + 40), "R3 low first 2");
      tx_take(pat(2 * p + 41), "R3 high second 2");
      if (p[0]) begin
        tx_wr(1'b0, 16'h0055);
        tx_take(8'h55, "R3 shift");
      end
    end

    // R8 overflow
    for (int k = 0; k < 3; k++) tx_wr(1'b0, {8'h00, pat(70 + k)});
    tx_wr(1'b1, 16'hDEAD);
    chk("R8 ovf on wide", int'(tx_ovf), 1);
    chk("R8 level kept", int'(tx_empty_flag), 0);
    tx_wr(1'b0, {8'h00, pat(73)});
    tx_wr(1'b0, 16'h00EE);
    chk("R8 sticky", int'(tx_ovf), 1);
    for (int k = 0; k < 4; k++) tx_take(pat(70 + k), "R8 contents");
    chk("R8 drained", int'(sh_tx_valid), 0);
    err_clr = 1'b1; step(); err_clr = 1'b0;
    chk("R10 ovf clr", int'(tx_ovf), 0);

    // R5 R6 R7: every receive level under both modes
    for (int bm = 0; bm < 2; bm++) begin
      byte_mode = bm[0];
      for (int lvl = 1; lvl <= 4; lvl++) begin
        rx_put(pat(100 + 10 * bm + lvl));
        if (bm == 1) chk("R5 rbne byte", int'(rx_ne_flag), int'(lvl >= 1));
        else         chk("R6 rbne packed", int'(rx_ne_flag), int'(lvl >= 2));
      end
      rd(1'b1, {pat(102 + 10 * bm), pat(101 + 10 * bm)}, "R7 wide read");
      rd(1'b0, {8'h00, pat(103 + 10 * bm)}, "R7 byte read");
      rd(1'b1, {8'h00, pat(104 + 10 * bm)}, "R7 odd tail");
      chk("R7 empty", int'(rx_ne_flag), 0);
    end

    // R6 odd tail needs byte mode
    byte_mode = 1'b0;
    rx_put(8'h3C);
    chk("R6 lone byte", int'(rx_ne_flag), 0);
    byte_mode = 1'b1; #1;
    chk("R5 lone byte", int'(rx_ne_flag), 1);
    rd(1'b0, 16'h003C, "R7 lone");

    // R9 overrun
    for (int k = 0; k < 4; k++) rx_put(pat(150 + k));
    chk("R9 no ovr yet", int'(rx_ovr), 0);
    rx_put(8'h99);
    chk("R9 ovr", int'(rx_ovr), 1);
    rd(1'b1, {pat(151), pat(150)}, "R9 contents");
    rd(1'b1, {pat(153), pat(152)}, "R9 contents");
    chk("R9 sticky", int'(rx_ovr), 1);
    err_clr = 1'b1; step(); err_clr = 1'b0;
    chk("R10 ovr clr", int'(rx_ovr), 0);

    // R12 empty read
    rd(1'b1, 16'h0000, "R12 empty read");
    chk("R12 rbne", int'(rx_ne_flag), 0);
    rx_put(8'h5A);
    chk("R12 after", int'(rx_ne_flag), 1);
    rd(1'b1, 16'h005A, "R12 data");
    chk("R12 drained", int'(rx_ne_flag), 0);

    finish_run();
  end
endmodule